// File: doc/BRIEF.md
# Hardware Zero-Overhead Loop Unit

This unit sits beside a program counter and repeats a block of code a counted number of times with no branch instruction at the bottom of the block. When a loop instruction executes, the decoder pulses a start strobe together with the loop instruction's own address, the loop end address and an iteration count. The unit stores the body's first address, which is the address just after the loop instruction, the end address and the count, and then watches the next-PC value that the fetch logic proposes.

Each time the proposed next PC equals the end address while a loop is active, the unit either sends fetch back to the first body address and decrements the remaining count, or, on the last pass, lets fetch proceed to the end address and goes idle. A loaded count of zero skips the body: fetch goes straight to the end address. There is one set of loop state, so a new loop instruction replaces any loop in progress. The loop cannot be interrupted. The body may call code elsewhere, because only an exact match on the end address has an effect. An active flag and the remaining count are brought out for observation.

The count comes either from a register operand or from an immediate field. A register count uses only its low 16 bits. An immediate count lies between 0 and 256.

Top module: `zol_unit`

## Requirements
- R1: After reset, active_o is 0, count_o is 0 and next_pc_o equals next_pc_i. At every clock edge out of reset, active_o is 1 exactly when count_o is non-zero.
- R2: When no loop is active and start_i is low, next_pc_o equals next_pc_i.
- R3: On a clock edge where start_i is 1 and the selected count N is non-zero, the unit arms. From the next cycle, active_o is 1, count_o is N, and the stored loop top is pc_i + 1. In the start cycle itself, next_pc_o equals next_pc_i.
- R4: While active with start_i low, if next_pc_i equals the stored end address and count_o is greater than 1, then next_pc_o equals the loop top in that cycle. In the next cycle, count_o is one lower and active_o stays 1.
- R5: While active with start_i low, if next_pc_i equals the stored end address and count_o is 1, then next_pc_o equals next_pc_i. In the next cycle, active_o is 0 and count_o is 0.
- R6: While active with start_i low, any next_pc_i other than the end address, including addresses outside the body, passes to next_pc_o unchanged, and count_o is unchanged.
- R7: With count_reg_i = 1 the selected count is count_i[15:0]. Bits 31..16 are ignored.
- R8: With count_reg_i = 0 the selected count is count_i[8:0], and a value above 256 is limited to 256. Bits 31..9 are ignored.
- R9: A start with a selected count of zero drives next_pc_o to end_addr_i in that cycle and leaves active_o at 0 and count_o at 0 afterwards. This also cancels any loop in progress.
- R10: A start while a loop is active replaces the end address, the loop top and the count. The old end address then passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Loop instruction executes this cycle |
| pc_i | input | 16 | Address of the loop instruction |
| end_addr_i | input | 16 | Loop end address |
| count_i | input | 32 | Raw iteration count operand |
| count_reg_i | input | 1 | 1: count comes from a register, 0: from an immediate |
| next_pc_i | input | 16 | Next PC proposed by the fetch logic |
| next_pc_o | output | 16 | Next PC after loop redirection |
| active_o | output | 1 | A loop is in progress |
| count_o | output | 16 | Remaining passes, including the current one |

## Verification
A three-pass loop checks every returned address and the count after each pass. This separates the redirect of a middle pass from the exit on the final pass. Register counts with high garbage bits and immediate counts above 256 or with bits set above bit 8 test the count selection. Two cases are each set against a normal start: a zero count, which must jump, and a second start over a live loop, which must drop the old end address. Addresses far outside the body during an active loop show that only the exact end address is acted on.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned SRC_W   = 32;
  localparam int unsigned IMM_MAX = 256;
  localparam int unsigned IMM_W   = $clog2(IMM_MAX + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/zol_count_sel.sv
module zol_count_sel
  import zol_pkg::*;
#(
  parameter int unsigned SRC_WIDTH = SRC_W,
  parameter int unsigned CNT_WIDTH = CNT_W,
  parameter int unsigned IMM_LIMIT = IMM_MAX
) (
  input  logic [SRC_WIDTH-1:0] src_i,
  input  logic                 reg_mode_i,
  output logic [CNT_WIDTH-1:0] cnt_o
);
  localparam int unsigned IW = $clog2(IMM_LIMIT + 1);

  logic [IW-1:0]        imm_raw;
  logic [CNT_WIDTH-1:0] imm_cnt;
  logic [CNT_WIDTH-1:0] reg_cnt;

  assign imm_raw = src_i[IW-1:0];
  assign reg_cnt = src_i[CNT_WIDTH-1:0];

  always_comb begin
    if (int'(imm_raw) > int'(IMM_LIMIT)) imm_cnt = CNT_WIDTH'(IMM_LIMIT);
    else                                 imm_cnt = CNT_WIDTH'(imm_raw);
  end

  assign cnt_o = reg_mode_i ? reg_cnt : imm_cnt;
endmodule

// File: rtl/zol_state.sv
module zol_state
  import zol_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  addr_t pc_i,
  input  addr_t end_i,
  input  cnt_t  cnt_i,
  input  logic  wrap_i,
  input  logic  last_i,
  output logic  active_o,
  output addr_t top_o,
  output addr_t end_o,
  output cnt_t  cnt_o
);
  logic  active_q;
  addr_t top_q, end_q;
  cnt_t  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      top_q    <= '0;
      end_q    <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      // a zero count loads an idle state (skip)
      active_q <= (cnt_i != '0);
      top_q    <= pc_i + ADDR_W'(1);
      end_q    <= end_i;
      cnt_q    <= cnt_i;
    end else if (wrap_i) begin
      cnt_q    <= cnt_q - CNT_W'(1);
    end else if (last_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end
  end

  assign active_o = active_q;
  assign top_o    = top_q;
  assign end_o    = end_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/zol_redirect.sv
module zol_redirect
  import zol_pkg::*;
(
  input  logic  start_i,
  input  cnt_t  start_cnt_i,
  input  addr_t start_end_i,
  input  logic  active_i,
  input  addr_t top_i,
  input  addr_t end_i,
  input  cnt_t  cnt_i,
  input  addr_t next_pc_i,
  output logic  wrap_o,
  output logic  last_o,
  output addr_t next_pc_o
);
  logic hit;

  assign hit    = active_i && !start_i && (next_pc_i == end_i);
  assign wrap_o = hit && (cnt_i > CNT_W'(1));
  assign last_o = hit && (cnt_i == CNT_W'(1));

  always_comb begin
    if (start_i && (start_cnt_i == '0)) next_pc_o = start_end_i;
    else if (wrap_o)                    next_pc_o = top_i;
    else                                next_pc_o = next_pc_i;
  end
endmodule

// File: rtl/zol_unit.sv
module zol_unit
  import zol_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [SRC_W-1:0]  count_i,
  input  logic              count_reg_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  count_o
);
  cnt_t  sel_cnt;
  addr_t top_q, end_q;
  logic  wrap, last;

  zol_count_sel #(
    .SRC_WIDTH(SRC_W),
    .CNT_WIDTH(CNT_W),
    .IMM_LIMIT(IMM_MAX)
  ) u_sel (
    .src_i     (count_i),
    .reg_mode_i(count_reg_i),
    .cnt_o     (sel_cnt)
  );

  zol_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .pc_i    (pc_i),
    .end_i   (end_addr_i),
    .cnt_i   (sel_cnt),
    .wrap_i  (wrap),
    .last_i  (last),
    .active_o(active_o),
    .top_o   (top_q),
    .end_o   (end_q),
    .cnt_o   (count_o)
  );

  zol_redirect u_redir (
    .start_i    (start_i),
    .start_cnt_i(sel_cnt),
    .start_end_i(end_addr_i),
    .active_i   (active_o),
    .top_i      (top_q),
    .end_i      (end_q),
    .cnt_i      (count_o),
    .next_pc_i  (next_pc_i),
    .wrap_o     (wrap),
    .last_o     (last),
    .next_pc_o  (next_pc_o)
  );
endmodule

// File: rtl/zol_unit_chk.sv
module zol_unit_chk
  import zol_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  start_i,
  input addr_t end_addr_i,
  input addr_t next_pc_i,
  input addr_t next_pc_o,
  input logic  active_o,
  input cnt_t  count_o,
  input cnt_t  sel_cnt,
  input addr_t top_q,
  input addr_t end_q
);
  a_r1_active_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == (count_o != '0));

  a_r2_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |-> (next_pc_o == next_pc_i));

  a_r3_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_cnt != '0) |=> (active_o && count_o == $past(sel_cnt)));

  a_r4_wrap_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && next_pc_i == end_q && count_o > 16'd1) |-> (next_pc_o == top_q));

  a_r4_wrap_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && next_pc_i == end_q && count_o > 16'd1)
      |=> (active_o && count_o == $past(count_o) - 16'd1));

  a_r5_last_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && next_pc_i == end_q && count_o == 16'd1)
      |=> (!active_o && count_o == '0));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && next_pc_i != end_q) |=> $stable(count_o));

  a_r6_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i && next_pc_i != end_q) |-> (next_pc_o == next_pc_i));

  a_r9_zero_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_cnt == '0) |-> (next_pc_o == end_addr_i));

  a_r9_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sel_cnt == '0) |=> !active_o);
endmodule

bind zol_unit zol_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .end_addr_i(end_addr_i),
  .next_pc_i (next_pc_i),
  .next_pc_o (next_pc_o),
  .active_o  (active_o),
  .count_o   (count_o),
  .sel_cnt   (sel_cnt),
  .top_q     (top_q),
  .end_q     (end_q)
);

// File: tb/zol_unit_test.sv
`timescale 1ns/1ps
module zol_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [15:0] end_addr_i = '0;
  logic [31:0] count_i = '0;
  logic        count_reg_i = 1'b0;
  logic [15:0] next_pc_i = '0;
  logic [15:0] next_pc_o;
  logic        active_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  zol_unit uut (
    .clk_i, .rst_ni, .start_i, .pc_i, .end_addr_i, .count_i,
    .count_reg_i, .next_pc_i, .next_pc_o, .active_o, .count_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive a loop start; checks next_pc_o in the start cycle
  task automatic start_loop(logic [15:0] pc, logic [15:0] e, logic [31:0] c,
                            logic rg, logic [15:0] exp_npc, string req);
    @(negedge clk_i);
    start_i = 1'b1; pc_i = pc; end_addr_i = e; count_i = c;
    count_reg_i = rg; next_pc_i = pc + 16'd1;
    #1 check(req, 32'(next_pc_o), 32'(exp_npc));
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic step(logic [15:0] npc, logic [15:0] exp, string req);
    @(negedge clk_i);
    start_i = 1'b0; next_pc_i = npc;
    #1 check(req, 32'(next_pc_o), 32'(exp));
    @(posedge clk_i); #1;
  endtask

  task automatic state(logic act, logic [15:0] cnt, string req);
    check({req, " active"}, 32'(active_o), 32'(act));
    check({req, " count"}, 32'(count_o), 32'(cnt));
  endtask

  task automatic t_reset;
    next_pc_i = 16'h1234;
    #1;
    state(1'b0, 16'd0, "R1 reset");
    check("R1 reset pass", 32'(next_pc_o), 32'h1234);
  endtask

  task automatic t_idle;
    step(16'h0044, 16'h0044, "R2 idle");
    step(16'h0014, 16'h0014, "R2 idle");
  endtask

  task automatic t_three_pass;
    start_loop(16'h0010, 16'h0014, 32'd3, 1'b1, 16'h0011, "R3 start pass");
    state(1'b1, 16'd3, "R3 armed");
    for (int p = 3; p >= 2; p--) begin
      step(16'h0012, 16'h0012, "R6 body");
      step(16'h0013, 16'h0013, "R6 body");
      step(16'h0014, 16'h0011, "R4 wrap");
      state(1'b1, 16'(p - 1), "R4 dec");
    end
    step(16'h0012, 16'h0012, "R6 body");
    step(16'h0014, 16'h0014, "R5 last");
    state(1'b0, 16'd0, "R5 exit");
    step(16'h0014, 16'h0014, "R2 after exit");
  endtask

  task automatic t_outside;
    start_loop(16'h0100, 16'h0108, 32'd2, 1'b1, 16'h0101, "R3 start pass");
    step(16'h8000, 16'h8000, "R6 call out");
    step(16'h0107, 16'h0107, "R6 near end");
    state(1'b1, 16'd2, "R6 hold");
    step(16'h0108, 16'h0101, "R4 wrap");
    step(16'h0108, 16'h0108, "R5 last");
    state(1'b0, 16'd0, "R5 exit");
  endtask

  task automatic t_zero;
    start_loop(16'h0200, 16'h0230, 32'd0, 1'b1, 16'h0230, "R9 skip");
    state(1'b0, 16'd0, "R9 idle");
    start_loop(16'h0200, 16'h0230, 32'h0001_0000, 1'b1, 16'h0230, "R7 R9 reg zero");
    start_loop(16'h0200, 16'h0230, 32'h0000_0200, 1'b0, 16'h0230, "R8 R9 imm zero");
    state(1'b0, 16'd0, "R9 idle imm");
    // zero start cancels a live loop
    start_loop(16'h0300, 16'h0304, 32'd5, 1'b1, 16'h0301, "R3 start pass");
    start_loop(16'h0302, 16'h0340, 32'd0, 1'b0, 16'h0340, "R9 cancel skip");
    state(1'b0, 16'd0, "R9 cancel");
    step(16'h0304, 16'h0304, "R9 old end pass");
  endtask

  task automatic t_count_sel;
    start_loop(16'h0400, 16'h0410, 32'hABCD_0102, 1'b1, 16'h0401, "R7 start");
    state(1'b1, 16'h0102, "R7 low16");
    start_loop(16'h0400, 16'h0410, 32'h0000_01FF, 1'b0, 16'h0401, "R8 start");
    state(1'b1, 16'd256, "R8 limit");
    start_loop(16'h0400, 16'h0410, 32'hFFFF_FE05, 1'b0, 16'h0401, "R8 start");
    state(1'b1, 16'd5, "R8 low9");
    start_loop(16'h0400, 16'h0410, 32'h0000_0100, 1'b0, 16'h0401, "R8 start");
    state(1'b1, 16'd256, "R8 max");
    start_loop(16'h0400, 16'h0410, 32'h0000_FFFF, 1'b1, 16'h0401, "R7 start");
    state(1'b1, 16'hFFFF, "R7 max");
  endtask

  task automatic t_overwrite;
    start_loop(16'h0500, 16'h0508, 32'd4, 1'b1, 16'h0501, "R3 start pass");
    step(16'h0508, 16'h0501, "R4 wrap");
    start_loop(16'h0600, 16'h0603, 32'd2, 1'b1, 16'h0601, "R10 restart");
    state(1'b1, 16'd2, "R10 count");
    step(16'h0508, 16'h0508, "R10 old end");
    state(1'b1, 16'd2, "R10 hold");
    step(16'h0603, 16'h0601, "R10 new top");
    step(16'h0603, 16'h0603, "R5 last");
    state(1'b0, 16'd0, "R5 exit");
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_idle();
    t_three_pass();
    t_outside();
    t_zero();
    t_count_sel();
    t_overwrite();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule